// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the device half of a descriptor-driven receive path. Software places a ring of descriptors in a shared memory. Each descriptor takes three consecutive 32-bit words: word 0 is a link to the next descriptor, word 1 is the command/status word, and word 2 is the buffer byte address. The engine walks the ring only by following links, so it never works out an index. It takes each descriptor that software has released and writes the bytes of one incoming frame into that descriptor's buffer. It then writes back a completed status word, which returns the descriptor to software.

Ownership sits in bit 31 of the status word. Software releases a descriptor by writing the buffer size into the low 12 bits with bit 31 clear. The engine sets bit 31 when it hands the descriptor back. The frame input is a byte stream with a last-byte flag and an error flag, and the bytes include the 4 CRC bytes. Three commands control the engine: on restarts a stopped or idle engine, off stops it at the next frame boundary, and reset returns it to the stopped state. A ring-base load sets the descriptor the engine will read next. A frame that arrives while the engine is not ready is dropped and counted.

Memory is one synchronous port addressed by 32-bit word. Read data appears on `mem_rdata` in the cycle after the read is issued. Every pointer held in memory is a byte address aligned to four bytes.

Top module: `rx_desc_ring`

## Requirements
- R1: After `rst_n` is released, or after a `cmd_rst` pulse, the engine is stopped, its pointer is word 0, it makes no memory access and drives no pulse, and `missed_cnt` is zero.
- R2: On `cmd_on`, the engine reads the status word of the current descriptor. If bit 31 is set, the engine writes nothing, raises `idle_pulse` for one cycle and waits for the next `cmd_on`, which re-reads the same descriptor.
- R3: After a write-back, the next descriptor is the one at the address held in word 0 of the finished descriptor, so a ring whose last link points to the first wraps around.
- R4: Byte k of a frame is written to buffer byte address + k. Each such write enables exactly one byte lane, lane = k mod 4.
- R5: The write-back puts the value 1 in bit 31, 0 in bit 30, and the number of bytes stored (CRC bytes included) in bits 11:0.
- R6: Bit 27 of the write-back is set only when the error flag was never seen during the frame and the frame fit in its buffer. Bit 22 is set when the frame was longer than the limit. Bytes past the limit are not written.
- R7: The byte limit is the low 12 bits of the status word software released. A value of 0, or a value above `BUF_BYTES`, selects `BUF_BYTES`.
- R8: `done_pulse` is high for exactly the cycle in which the status word is written back, once per frame.
- R9: A frame whose first byte arrives while the engine is not waiting for one is dropped with no memory write, and `missed_cnt` rises by one, saturating at its maximum.
- R10: `cmd_off` lets the current frame finish, including a frame whose first byte arrives in the same cycle, and the engine stops after its write-back. Later frames are dropped.
- R11: A ring-base load takes effect only while the engine is stopped or idle. At any other time it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_load | input | 1 | Load `base_word` as the current descriptor |
| base_word | input | AW | Word address of a descriptor |
| cmd_on | input | 1 | Start or restart the engine |
| cmd_off | input | 1 | Stop at the next frame boundary |
| cmd_rst | input | 1 | Return to stopped, clear counter and pointer |
| rx_valid | input | 1 | Frame byte valid |
| rx_byte | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_err | input | 1 | Frame error flag, sampled with each valid byte |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after the read |
| done_pulse | output | 1 | Status write-back in this cycle |
| idle_pulse | output | 1 | Reached a descriptor it does not own |
| missed_cnt | output | MISS_W | Saturating count of dropped frames |

## Verification
A stop command and the first byte of a new frame can land in the same cycle. The engine must then take the frame, finish it, and stop only after its write-back. The bench provokes this by raising `cmd_off` on the same clock as the first valid byte. It judges the result in two ways: the descriptor must come back with a correct status and buffer contents, and the next frame must be counted as missed with no further write-back. Frame start against ownership loss is provoked too, by letting the ring wrap onto a descriptor still held by software and then sending a frame into the idle engine.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int LEN_W    = 12;
  localparam int OWN_BIT  = 31;
  localparam int MORE_BIT = 30;
  localparam int OK_BIT   = 27;
  localparam int LONG_BIT = 22;

  // word offsets inside one descriptor record
  localparam int OFS_LINK = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_BUF  = 2;

  typedef enum logic [3:0] {
    ST_STOP,
    ST_RD_STAT,
    ST_CHK,
    ST_BUF,
    ST_LINK,
    ST_ARMED,
    ST_RECV,
    ST_WB,
    ST_IDLE
  } rx_state_e;

  // byte limit for one buffer: zero or oversize falls back to the cap
  function automatic logic [LEN_W-1:0] pick_limit(input logic [LEN_W-1:0] sz,
                                                   input logic [LEN_W-1:0] cap);
    return ((sz == '0) || (sz > cap)) ? cap : sz;
  endfunction

endpackage

// File: rtl/rxr_sof_track.sv
module rxr_sof_track (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic last,
  output logic sof
);

  logic in_frame_q;
  logic in_frame_d;

  always_comb begin
    in_frame_d = in_frame_q;
    if (valid) in_frame_d = !last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_frame_q <= 1'b0;
    else        in_frame_q <= in_frame_d;
  end

  assign sof = valid && !in_frame_q;

endmodule

// File: rtl/rxr_miss_ctr.sv
module rxr_miss_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                       cnt_d = '0;
    else if (inc && cnt_q != TOP)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/rxr_lane_wr.sv
module rxr_lane_wr (
  input  logic [7:0]  byte_in,
  input  logic [1:0]  lane,
  output logic [31:0] wdata,
  output logic [3:0]  be
);

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign wdata[8*g +: 8] = byte_in;
    assign be[g]           = (lane == 2'(g));
  end

endmodule

// File: rtl/rxr_stat_fmt.sv
module rxr_stat_fmt
  import rxr_pkg::*;
(
  input  logic [LEN_W-1:0] count,
  input  logic             too_long,
  input  logic             bad,
  output logic [31:0]      word
);

  always_comb begin
    word                 = '0;
    word[OWN_BIT]        = 1'b1;
    word[MORE_BIT]       = 1'b0;
    word[OK_BIT]         = !too_long && !bad;
    word[LONG_BIT]       = too_long;
    word[LEN_W-1:0]      = count;
  end

endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
  import rxr_pkg::*;
#(
  parameter int AW        = 12,
  parameter int BUF_BYTES = 1536,
  parameter int MISS_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_load,
  input  logic [AW-1:0]     base_word,
  input  logic              cmd_on,
  input  logic              cmd_off,
  input  logic              cmd_rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_last,
  input  logic              rx_err,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              done_pulse,
  output logic              idle_pulse,
  output logic [MISS_W-1:0] missed_cnt
);

  localparam logic [LEN_W-1:0] CAP = LEN_W'(BUF_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // state
  rx_state_e        state_q, state_d;
  logic [AW-1:0]    cur_q,  cur_d;
  logic [AW-1:0]    link_q, link_d;
  logic [AW-1:0]    buf_q,  buf_d;
  logic [LEN_W-1:0] lim_q,  lim_d;
  logic [LEN_W-1:0] cnt_q,  cnt_d;
  logic             ovf_q,  ovf_d;
  logic             err_q,  err_d;
  logic             stop_q, stop_d;

  // helpers
  logic             sof;
  logic             miss_inc;
  logic [31:0]      lane_wdata;
  logic [3:0]       lane_be;
  logic [31:0]      stat_word;
  logic [AW-1:0]    wr_word;
  logic             stop_now;
  logic             unused_rdata_par;

  assign unused_rdata_par = ^mem_rdata;

  rxr_sof_track u_sof (
    .clk   (clk),
    .rst_n (rst_core_n),
    .valid (rx_valid),
    .last  (rx_last),
    .sof   (sof)
  );

  assign miss_inc = sof && (state_q != ST_ARMED);

  rxr_miss_ctr #(.W(MISS_W)) u_miss (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (cmd_rst),
    .inc   (miss_inc),
    .count (missed_cnt)
  );

  rxr_lane_wr u_lane (
    .byte_in (rx_byte),
    .lane    (cnt_q[1:0]),
    .wdata   (lane_wdata),
    .be      (lane_be)
  );

  rxr_stat_fmt u_fmt (
    .count    (cnt_q),
    .too_long (ovf_q),
    .bad      (err_q),
    .word     (stat_word)
  );

  assign wr_word  = buf_q + AW'(cnt_q >> 2);
  assign stop_now = stop_q || cmd_off;

  // next state and memory port
  always_comb begin
    state_d    = state_q;
    cur_d      = cur_q;
    link_d     = link_q;
    buf_d      = buf_q;
    lim_d      = lim_q;
    cnt_d      = cnt_q;
    ovf_d      = ovf_q;
    err_d      = err_q;
    stop_d     = stop_q;
    mem_en     = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = cur_q;
    mem_be     = 4'h0;
    mem_wdata  = lane_wdata;
    done_pulse = 1'b0;
    idle_pulse = 1'b0;

    case (state_q)
      ST_STOP: begin
        stop_d = 1'b0;
        if (base_load) cur_d = base_word;
        if (cmd_on && !cmd_off) state_d = ST_RD_STAT;
      end

      ST_IDLE: begin
        if (base_load) cur_d = base_word;
        if (cmd_off)     state_d = ST_STOP;
        else if (cmd_on) state_d = ST_RD_STAT;
      end

      ST_RD_STAT: begin
        mem_en   = 1'b1;
        mem_addr = cur_q + AW'(OFS_STAT);
        if (cmd_off) stop_d = 1'b1;
        state_d  = ST_CHK;
      end

      ST_CHK: begin
        if (mem_rdata[OWN_BIT]) begin
          stop_d = 1'b0;
          if (stop_now) begin
            state_d = ST_STOP;
          end else begin
            state_d    = ST_IDLE;
            idle_pulse = 1'b1;
          end
        end else begin
          lim_d    = pick_limit(mem_rdata[LEN_W-1:0], CAP);
          mem_en   = 1'b1;
          mem_addr = cur_q + AW'(OFS_BUF);
          if (cmd_off) stop_d = 1'b1;
          state_d  = ST_BUF;
        end
      end

      ST_BUF: begin
        buf_d    = mem_rdata[AW+1:2];
        mem_en   = 1'b1;
        mem_addr = cur_q + AW'(OFS_LINK);
        if (cmd_off) stop_d = 1'b1;
        state_d  = ST_LINK;
      end

      ST_LINK: begin
        link_d  = mem_rdata[AW+1:2];
        cnt_d   = '0;
        ovf_d   = 1'b0;
        err_d   = 1'b0;
        if (cmd_off) stop_d = 1'b1;
        state_d = ST_ARMED;
      end

      ST_ARMED: begin
        if (sof) begin
          mem_en   = 1'b1;
          mem_we   = 1'b1;
          mem_addr = wr_word;
          mem_be   = lane_be;
          cnt_d    = cnt_q + 1'b1;
          err_d    = rx_err;
          if (cmd_off) stop_d = 1'b1;
          state_d  = rx_last ? ST_WB : ST_RECV;
        end else if (stop_now) begin
          stop_d  = 1'b0;
          state_d = ST_STOP;
        end
      end

      ST_RECV: begin
        if (cmd_off) stop_d = 1'b1;
        if (rx_valid) begin
          err_d = err_q || rx_err;
          if (cnt_q < lim_q) begin
            mem_en   = 1'b1;
            mem_we   = 1'b1;
            mem_addr = wr_word;
            mem_be   = lane_be;
            cnt_d    = cnt_q + 1'b1;
          end else begin
            ovf_d = 1'b1;
          end
          if (rx_last) state_d = ST_WB;
        end
      end

      ST_WB: begin
        mem_en     = 1'b1;
        mem_we     = 1'b1;
        mem_addr   = cur_q + AW'(OFS_STAT);
        mem_be     = 4'hF;
        mem_wdata  = stat_word;
        done_pulse = 1'b1;
        cur_d      = link_q;
        if (stop_now) begin
          stop_d  = 1'b0;
          state_d = ST_STOP;
        end else begin
          state_d = ST_RD_STAT;
        end
      end

      default: state_d = ST_STOP;
    endcase

    if (cmd_rst) begin
      state_d    = ST_STOP;
      cur_d      = '0;
      stop_d     = 1'b0;
      mem_en     = 1'b0;
      mem_we     = 1'b0;
      mem_be     = 4'h0;
      done_pulse = 1'b0;
      idle_pulse = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_STOP;
      cur_q   <= '0;
      link_q  <= '0;
      buf_q   <= '0;
      lim_q   <= '0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      err_q   <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      link_q  <= link_d;
      buf_q   <= buf_d;
      lim_q   <= lim_d;
      cnt_q   <= cnt_d;
      ovf_q   <= ovf_d;
      err_q   <= err_d;
      stop_q  <= stop_d;
    end
  end

endmodule

// File: rtl/rxr_chk.sv
module rxr_chk #(
  parameter int AW     = 12,
  parameter int MISS_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_en,
  input logic              mem_we,
  input logic [3:0]        mem_be,
  input logic [31:0]       mem_wdata,
  input logic              done_pulse,
  input logic              idle_pulse,
  input logic [MISS_W-1:0] missed_cnt
);

  a_r8_done_is_status_write: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (mem_en && mem_we && (mem_be == 4'hF) && mem_wdata[31]));

  a_r5_wb_fields: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (!mem_wdata[30] && (mem_wdata[11:0] != 12'd0)));

  a_r6_ok_excludes_long: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !(mem_wdata[27] && mem_wdata[22]));

  a_r4_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !done_pulse) |-> ($countones(mem_be) == 1));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse |=> !mem_en);

  a_r1_pulses_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_pulse && idle_pulse));

  a_r9_missed_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(missed_cnt) |-> ((missed_cnt == $past(missed_cnt) + 1'b1) || (missed_cnt == '0)));

endmodule

bind rx_desc_ring rxr_chk #(.AW(AW), .MISS_W(MISS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_en     (mem_en),
  .mem_we     (mem_we),
  .mem_be     (mem_be),
  .mem_wdata  (mem_wdata),
  .done_pulse (done_pulse),
  .idle_pulse (idle_pulse),
  .missed_cnt (missed_cnt)
);

// File: tb/rx_desc_ring_tb.sv
module rx_desc_ring_tb;

  localparam int AW  = 10;
  localparam int BUF = 256;
  localparam int MW  = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          base_load, cmd_on, cmd_off, cmd_rst;
  logic [AW-1:0] base_word;
  logic          rx_valid, rx_last, rx_err;
  logic [7:0]    rx_byte;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          done_pulse, idle_pulse;
  logic [MW-1:0] missed_cnt;

  int total = 0, bad = 0, done_seen = 0, idle_seen = 0, fno = 0, ridx = 0;
  logic [31:0] mem [0:(1<<AW)-1];

  always #5 clk = ~clk;

  rx_desc_ring #(.AW(AW), .BUF_BYTES(BUF), .MISS_W(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .base_load(base_load), .base_word(base_word),
    .cmd_on(cmd_on), .cmd_off(cmd_off), .cmd_rst(cmd_rst),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last), .rx_err(rx_err),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done_pulse(done_pulse), .idle_pulse(idle_pulse), .missed_cnt(missed_cnt));

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && done_pulse) done_seen++;
    if (rst_n && idle_pulse) idle_seen++;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int f, input int i);
    return 8'((f * 37 + i * 7 + 3) & 255);
  endfunction

  function automatic logic [7:0] mbyte(input int a);
    return mem[a >> 2][8 * (a & 3) +: 8];
  endfunction

  function automatic logic [31:0] exp_stat(input int len, input bit err, input int lim);
    bit ovf;
    int n;
    ovf = (len > lim);
    n   = ovf ? lim : len;
    return 32'h8000_0000 | (ovf ? 32'h0040_0000 : 32'h0)
         | ((!ovf && !err) ? 32'h0800_0000 : 32'h0) | 32'(n);
  endfunction

  task automatic hand(input int idx, input int size);
    for (int w = 0; w < BUF / 4; w++) mem[(BUF * (idx + 1)) / 4 + w] = 32'hA5A5_A5A5;
    mem[idx * 4 + 1] = 32'(size);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int len, input bit err, input bit off_first, input bit gaps);
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      if (gaps && i > 0 && $urandom_range(0, 3) == 0) begin
        rx_valid = 1'b0;
        cmd_off  = 1'b0;
        @(negedge clk);
      end
      rx_valid = 1'b1;
      rx_byte  = pat(fno, i);
      rx_last  = (i == len - 1);
      rx_err   = err && (i == len - 1);
      cmd_off  = off_first && (i == 0);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0; cmd_off = 1'b0;
    idle_cycles(10);
  endtask

  task automatic check_frame(input int idx, input int len, input bit err, input int lim, input string tag);
    int  n;
    int  base;
    bit  ok;
    logic [31:0] st;
    base = BUF * (idx + 1);
    n    = (len > lim) ? lim : len;
    st   = mem[idx * 4 + 1];
    check(st == exp_stat(len, err, lim), {tag, " R5 R6 status"}, st, exp_stat(len, err, lim));
    ok = 1'b1;
    for (int i = 0; i < n; i++) if (mbyte(base + i) != pat(fno, i)) ok = 1'b0;
    check(ok, {tag, " R4 data"}, 32'(n), 32'(len));
    if (len > lim)
      check(mbyte(base + lim) == 8'hA5, {tag, " R6 no write past limit"},
            32'(mbyte(base + lim)), 32'hA5);
    fno++;
  endtask

  task automatic pulse_on();
    @(negedge clk); cmd_on = 1'b1;
    @(negedge clk); cmd_on = 1'b0;
    idle_cycles(8);
  endtask

  initial begin
    int len;
    bit err;
    void'($urandom(32'd4242));
    rst_n = 1'b0; base_load = 0; base_word = '0; cmd_on = 0; cmd_off = 0; cmd_rst = 0;
    rx_valid = 0; rx_last = 0; rx_err = 0; rx_byte = '0;
    for (int w = 0; w < (1 << AW); w++) mem[w] = 32'h0;
    for (int i = 0; i < 4; i++) begin
      mem[i * 4]     = 32'(((i + 1) % 4) * 16);
      mem[i * 4 + 2] = 32'(BUF * (i + 1));
      hand(i, 0);
    end
    hand(3, 32);
    idle_cycles(4);
    rst_n = 1'b1;
    idle_cycles(5);

    // R1 reset state
    check(missed_cnt == '0, "R1 missed after reset", 32'(missed_cnt), 0);
    check(!mem_en && !done_pulse && !idle_pulse, "R1 quiet after reset",
          {29'd0, mem_en, done_pulse, idle_pulse}, 0);

    pulse_on();
    // directed frames: normal, single byte, error, overflow with size 32 (R7)
    send(64, 0, 0, 0); check_frame(0, 64, 0, BUF, "R3 desc0");
    send(1, 0, 0, 0);  check_frame(1, 1, 0, BUF, "R4 single byte");
    send(20, 1, 0, 1); check_frame(2, 20, 1, BUF, "R6 error frame");
    send(40, 0, 0, 0); check_frame(3, 40, 0, 32, "R7 size from descriptor");
    check(done_seen == 4, "R8 one done per frame", 32'(done_seen), 4);

    // R2 wrap onto a descriptor software still holds
    check(idle_seen == 1, "R2 idle pulse", 32'(idle_seen), 1);
    check(mem[1] == exp_stat(64, 0, BUF), "R2 owned desc untouched", mem[1], exp_stat(64, 0, BUF));
    send(10, 0, 0, 0); fno++;
    check(missed_cnt == 1, "R9 dropped while idle", 32'(missed_cnt), 1);
    check(done_seen == 4, "R9 no write-back for dropped", 32'(done_seen), 4);

    // random traffic, re-handing every descriptor after its check
    for (int i = 0; i < 4; i++) hand(i, 0);
    pulse_on();
    ridx = 0;
    for (int k = 0; k < 12; k++) begin
      len = $urandom_range(1, 300);
      err = ($urandom_range(0, 3) == 0);
      send(len, err, 0, 1);
      check_frame(ridx, len, err, BUF, "R3 R7 random");
      hand(ridx, 0);
      ridx = (ridx + 1) % 4;
    end
    check(done_seen == 16, "R8 done count", 32'(done_seen), 16);

    // R10 stop coincides with first byte
    send(30, 0, 1, 0); check_frame(0, 30, 0, BUF, "R10 frame with stop");
    hand(0, 0);
    send(12, 0, 0, 0); fno++;
    check(missed_cnt == 2, "R10 stopped after frame", 32'(missed_cnt), 2);
    check(done_seen == 17, "R10 no extra write-back", 32'(done_seen), 17);

    // R11 base load while stopped, then ignored while armed
    @(negedge clk); base_load = 1'b1; base_word = AW'(8);
    @(negedge clk); base_load = 1'b0;
    pulse_on();
    send(16, 0, 0, 0); check_frame(2, 16, 0, BUF, "R11 load while stopped");
    @(negedge clk); base_load = 1'b1; base_word = '0;
    @(negedge clk); base_load = 1'b0;
    send(18, 0, 0, 0); check_frame(3, 18, 0, BUF, "R11 load ignored while armed");

    // R1 command reset, then R9 saturation
    @(negedge clk); cmd_rst = 1'b1;
    @(negedge clk); cmd_rst = 1'b0;
    @(negedge clk);
    check(missed_cnt == '0, "R1 cmd reset clears counter", 32'(missed_cnt), 0);
    for (int k = 0; k < 20; k++) begin send(2, 0, 0, 0); fno++; end
    check(missed_cnt == 4'hF, "R9 saturating", 32'(missed_cnt), 15);
    check(done_seen == 19, "R1 stopped after cmd reset", 32'(done_seen), 19);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", total);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule